// File: doc/BRIEF.md
# Sleep Timer with Tick-Counting Watchdog

This block keeps time in a slow always-on clock domain. A free-running counter divides the clock and emits a one-cycle terminal-count tick at a selectable power-of-two interval. A watchdog counts those ticks rather than raw clocks. When it sees the third tick since it was last cleared, it raises a one-cycle reset request. Firmware clears the watchdog through a byte-wide write port. One key value also restarts the divider, which guarantees a full three-interval timeout. Any other value leaves the divider running, so the timeout then depends on where in the current interval the clear lands.

A sleep flag is set by a firmware write. It is cleared by a wakeup input, which is synchronized into the clock domain first. While the flag is set, a buzz sequencer runs once every `BUZZ_PERIOD` clocks. In each buzz it raises the bandgap enable for two cycles and the low-voltage-detect enable in the second of those cycles. This keeps supply monitoring alive during sleep. Both enables are plain outputs.

Top module: `sleep_wdt_timer`

## Requirements
- R1: The tick interval is 2^(BASE_LOG2 + intervalSel) clocks (8, 16, 32 or 64 with defaults). `sleepTick` is high for exactly one cycle when the low log2(interval) bits of the divider are all ones. A change of `intervalSel` applies at once.
- R2: Ticks counted since reset or the last watchdog clear are tallied. `wdtReset` rises in the cycle after the third such tick is visible.
- R3: `wdtReset` is high for one cycle only. The tally then saturates, and further ticks raise no request until a clear.
- R4: A clear write with data 0x38 zeroes both the divider and the tally on the next edge. The next reset request therefore comes exactly 3 intervals after that edge.
- R5: A clear write with any other data zeroes only the tally. The divider phase, and so the tick times, are unaffected.
- R6: A clear applied on the same edge as a visible tick wins: that tick is not counted.
- R7: A `sleepSetWr` pulse sets `sleepFlag` on the next edge. `wakeIn` passes a two-stage synchronizer and clears `sleepFlag` on the third edge after it is sampled high. The wakeup takes priority over a set.
- R8: While asleep, with buzz phase k counting 0..BUZZ_PERIOD-1 from the edge that set the flag, `bgEnable` is high at k = BUZZ_PERIOD-2 and k = BUZZ_PERIOD-1. `lvdEnable` is high only at k = BUZZ_PERIOD-1.
- R9: With `sleepFlag` low, both enables stay low. Each entry into sleep restarts the buzz phase at zero.
- R10: While `rstN` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rstN | input | 1 | Active-low power-on reset |
| intervalSel | input | 2 | Tick interval select |
| wdtClrWr | input | 1 | Watchdog clear write strobe |
| wdtClrData | input | 8 | Clear write data; 0x38 also restarts the divider |
| sleepSetWr | input | 1 | Write strobe that sets the sleep flag |
| wakeIn | input | 1 | Asynchronous wakeup request |
| sleepTick | output | 1 | One-cycle terminal-count tick |
| wdtReset | output | 1 | One-cycle watchdog reset request |
| sleepFlag | output | 1 | Sleep state |
| bgEnable | output | 1 | Bandgap enable during buzz |
| lvdEnable | output | 1 | Low-voltage-detect enable during buzz |

## Verification
The bench places a plain clear right before a tick. A design that also restarted the divider would shift the tick and stretch the timeout to a full three intervals instead of just over two. A clear in the same cycle as a tick catches a design that counts the tick anyway, which would fire the request one interval early. After expiry, further ticks must not raise the request again, as they would if the tally wrapped instead of saturating. The buzz pattern is checked across two periods, around a wakeup, and on re-entry into sleep. This exposes an LVD pulse outside the bandgap window, a buzz while awake, and a phase that fails to restart.

// File: rtl/sleep_wdt_pkg.sv
package sleep_wdt_pkg;

  // Strobes handed from the control module to the datapath
  typedef struct packed {
    logic clrTimer;  // restart the divider
    logic clrWdog;   // zero the watchdog tally
    logic setSleep;  // enter sleep
    logic wake;      // synchronized wakeup level
  } ctrlStrobe_t;

  localparam logic [7:0] FULL_CLR_KEY = 8'h38;

endpackage

// File: rtl/sleep_wdt_ctrl.sv
module sleep_wdt_ctrl
  import sleep_wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wdtClrWr,
  input  logic [7:0]  wdtClrData,
  input  logic        sleepSetWr,
  input  logic        wakeIn,
  output ctrlStrobe_t strobe
);

  logic [SYNC_STAGES-1:0] wakeSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeSync <= '0;
    else       wakeSync <= {wakeSync[SYNC_STAGES-2:0], wakeIn};
  end

  always_comb begin
    strobe.clrWdog  = wdtClrWr;
    strobe.clrTimer = wdtClrWr && (wdtClrData == FULL_CLR_KEY);
    strobe.setSleep = sleepSetWr;
    strobe.wake     = wakeSync[SYNC_STAGES-1];
  end

endmodule

// File: rtl/sleep_wdt_datapath.sv
module sleep_wdt_datapath
  import sleep_wdt_pkg::*;
#(
  parameter int TIMER_W     = 8,
  parameter int BASE_LOG2   = 3,
  parameter int WDT_LIMIT   = 3,
  parameter int BUZZ_PERIOD = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  intervalSel,
  input  ctrlStrobe_t strobe,
  output logic        sleepTick,
  output logic        wdtReset,
  output logic        sleepFlag,
  output logic        bgEnable,
  output logic        lvdEnable
);

  localparam int WCNT_W = $clog2(WDT_LIMIT + 1);
  localparam int BUZZ_W = $clog2(BUZZ_PERIOD);
  localparam logic [WCNT_W-1:0] WDT_MAX  = WCNT_W'(WDT_LIMIT);
  localparam logic [WCNT_W-1:0] WDT_LAST = WCNT_W'(WDT_LIMIT - 1);
  localparam logic [BUZZ_W-1:0] BUZZ_END = BUZZ_W'(BUZZ_PERIOD - 1);
  localparam logic [BUZZ_W-1:0] BUZZ_BG  = BUZZ_W'(BUZZ_PERIOD - 2);

  logic [TIMER_W-1:0] timerCnt;
  logic [TIMER_W-1:0] tickMask;
  logic [WCNT_W-1:0]  wdogCnt;
  logic [BUZZ_W-1:0]  buzzCnt;

  // Divider and terminal count
  always_comb begin
    tickMask  = (TIMER_W'(1) << (BASE_LOG2 + int'(intervalSel))) - TIMER_W'(1);
    sleepTick = (timerCnt & tickMask) == tickMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timerCnt <= '0;
    else if (strobe.clrTimer) timerCnt <= '0;
    else                      timerCnt <= timerCnt + TIMER_W'(1);
  end

  // Watchdog tally of ticks, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdogCnt  <= '0;
      wdtReset <= 1'b0;
    end else begin
      wdtReset <= !strobe.clrWdog && sleepTick && (wdogCnt == WDT_LAST);
      if (strobe.clrWdog)                        wdogCnt <= '0;
      else if (sleepTick && wdogCnt != WDT_MAX)  wdogCnt <= wdogCnt + WCNT_W'(1);
    end
  end

  // Sleep flag and buzz sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sleepFlag <= 1'b0;
    else if (strobe.wake)     sleepFlag <= 1'b0;
    else if (strobe.setSleep) sleepFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    buzzCnt <= '0;
    else if (!sleepFlag)          buzzCnt <= '0;
    else if (buzzCnt == BUZZ_END) buzzCnt <= '0;
    else                          buzzCnt <= buzzCnt + BUZZ_W'(1);
  end

  always_comb begin
    bgEnable  = sleepFlag && (buzzCnt >= BUZZ_BG);
    lvdEnable = sleepFlag && (buzzCnt == BUZZ_END);
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sleepTick |=> !sleepTick); // R1
  AST_WDT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |-> ($past(sleepTick) && !$past(strobe.clrWdog))); // R2
  AST_WDT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |=> !wdtReset); // R3
  AST_FULL_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrTimer |=> (timerCnt == '0)); // R4
  AST_WAKE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wake |=> !sleepFlag); // R7
  AST_LVD_IN_BG: assert property (@(posedge clk) disable iff (!rstN)
    lvdEnable |-> (bgEnable && $past(bgEnable))); // R8

endmodule

// File: rtl/sleep_wdt_timer.sv
module sleep_wdt_timer
  import sleep_wdt_pkg::*;
#(
  parameter int TIMER_W     = 8,
  parameter int BASE_LOG2   = 3,
  parameter int WDT_LIMIT   = 3,
  parameter int BUZZ_PERIOD = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] intervalSel,
  input  logic       wdtClrWr,
  input  logic [7:0] wdtClrData,
  input  logic       sleepSetWr,
  input  logic       wakeIn,
  output logic       sleepTick,
  output logic       wdtReset,
  output logic       sleepFlag,
  output logic       bgEnable,
  output logic       lvdEnable
);

  ctrlStrobe_t strobe;

  sleep_wdt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .wdtClrWr(wdtClrWr), .wdtClrData(wdtClrData),
    .sleepSetWr(sleepSetWr), .wakeIn(wakeIn), .strobe(strobe)
  );

  sleep_wdt_datapath #(
    .TIMER_W(TIMER_W), .BASE_LOG2(BASE_LOG2),
    .WDT_LIMIT(WDT_LIMIT), .BUZZ_PERIOD(BUZZ_PERIOD)
  ) uData (
    .clk(clk), .rstN(rstN), .intervalSel(intervalSel), .strobe(strobe),
    .sleepTick(sleepTick), .wdtReset(wdtReset), .sleepFlag(sleepFlag),
    .bgEnable(bgEnable), .lvdEnable(lvdEnable)
  );

endmodule

// File: tb/sleep_wdt_timer_test.sv
module sleep_wdt_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] intervalSel = 2'd0;
  logic       wdtClrWr = 1'b0;
  logic [7:0] wdtClrData = 8'h00;
  logic       sleepSetWr = 1'b0;
  logic       wakeIn = 1'b0;
  logic       sleepTick, wdtReset, sleepFlag, bgEnable, lvdEnable;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    int    kind;   // 0 tick, 1 wdt, 2 bg, 3 lvd, 4 sleep
    bit    val;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  sleep_wdt_timer uut (
    .clk(clk), .rstN(rstN), .intervalSel(intervalSel), .wdtClrWr(wdtClrWr),
    .wdtClrData(wdtClrData), .sleepSetWr(sleepSetWr), .wakeIn(wakeIn),
    .sleepTick(sleepTick), .wdtReset(wdtReset), .sleepFlag(sleepFlag),
    .bgEnable(bgEnable), .lvdEnable(lvdEnable)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  function automatic bit pick(int kind);
    case (kind)
      0: return sleepTick;
      1: return wdtReset;
      2: return bgEnable;
      3: return lvdEnable;
      default: return sleepFlag;
    endcase
  endfunction

  task automatic check(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic expectAt(int at, int kind, bit val, string req);
    expItem_t it;
    it.at = at; it.kind = kind; it.val = val; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic waitCyc(int c);
    while (cyc != c) @(negedge clk);
  endtask

  // Monitor: pops the expectations that fall due in this cycle
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      for (int i = expQ.size() - 1; i >= 0; i--) begin
        if (expQ[i].at == cyc) begin
          check(expQ[i].req, $sformatf("kind%0d", expQ[i].kind),
                pick(expQ[i].kind), expQ[i].val);
          expQ.delete(i);
        end
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  initial begin
    // R1, R2, R3: free run from reset with interval 8
    expectAt(6, 0, 0, "R1"); expectAt(7, 0, 1, "R1"); expectAt(8, 0, 0, "R1");
    expectAt(15, 0, 1, "R1"); expectAt(23, 0, 1, "R1");
    expectAt(23, 1, 0, "R2"); expectAt(24, 1, 1, "R2");
    expectAt(25, 1, 0, "R3"); expectAt(31, 0, 1, "R3");
    expectAt(32, 1, 0, "R3"); expectAt(40, 1, 0, "R3");
    // R4: key clear at edge 46
    expectAt(47, 0, 0, "R4"); expectAt(53, 0, 1, "R4"); expectAt(61, 0, 1, "R4");
    expectAt(62, 1, 0, "R4"); expectAt(69, 0, 1, "R4"); expectAt(70, 1, 1, "R4");
    // R5: plain clear at edge 77, just before a tick
    expectAt(77, 0, 1, "R5"); expectAt(85, 0, 1, "R5"); expectAt(93, 0, 1, "R5");
    expectAt(93, 1, 0, "R5"); expectAt(94, 1, 1, "R5");
    // R6: clear on the edge that would count the tick at 101
    expectAt(101, 0, 1, "R6"); expectAt(118, 1, 0, "R6"); expectAt(126, 1, 1, "R6");
    // R1, R2: interval 32 with key clear at edge 131
    expectAt(138, 0, 0, "R1"); expectAt(161, 0, 0, "R1"); expectAt(162, 0, 1, "R1");
    expectAt(194, 0, 1, "R1"); expectAt(226, 1, 0, "R2"); expectAt(227, 1, 1, "R2");
    // R7, R8, R9: sleep, buzz, wake, re-entry
    expectAt(200, 2, 0, "R9");
    expectAt(240, 4, 0, "R7"); expectAt(241, 4, 1, "R7");
    expectAt(270, 2, 0, "R8"); expectAt(271, 2, 1, "R8"); expectAt(271, 3, 0, "R8");
    expectAt(272, 2, 1, "R8"); expectAt(272, 3, 1, "R8");
    expectAt(273, 2, 0, "R8"); expectAt(273, 3, 0, "R8");
    expectAt(303, 2, 1, "R8"); expectAt(304, 3, 1, "R8");
    expectAt(312, 4, 1, "R7"); expectAt(313, 4, 0, "R7");
    expectAt(335, 2, 0, "R9"); expectAt(336, 2, 0, "R9");
    expectAt(341, 4, 1, "R7"); expectAt(370, 2, 0, "R9");
    expectAt(371, 2, 1, "R9"); expectAt(372, 3, 1, "R9");

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "sleepTick", sleepTick, 1'b0);
    check("R10", "wdtReset", wdtReset, 1'b0);
    check("R10", "sleepFlag", sleepFlag, 1'b0);
    check("R10", "bgEnable", bgEnable, 1'b0);
    check("R10", "lvdEnable", lvdEnable, 1'b0);
    rstN = 1'b1;

    waitCyc(45);  wdtClrWr = 1'b1; wdtClrData = 8'h38;
    waitCyc(46);  wdtClrWr = 1'b0;
    waitCyc(76);  wdtClrWr = 1'b1; wdtClrData = 8'h11;
    waitCyc(77);  wdtClrWr = 1'b0;
    waitCyc(101); wdtClrWr = 1'b1; wdtClrData = 8'h00;
    waitCyc(102); wdtClrWr = 1'b0;
    waitCyc(130); wdtClrWr = 1'b1; wdtClrData = 8'h38; intervalSel = 2'd2;
    waitCyc(131); wdtClrWr = 1'b0;
    waitCyc(240); sleepSetWr = 1'b1;
    waitCyc(241); sleepSetWr = 1'b0;
    waitCyc(310); wakeIn = 1'b1;
    waitCyc(313); wakeIn = 1'b0;
    waitCyc(340); sleepSetWr = 1'b1;
    waitCyc(341); sleepSetWr = 1'b0;
    waitCyc(380);
    @(negedge clk);
    #2;
    if (expQ.size() != 0) begin
      foreach (expQ[i]) begin
        checks++; fails++;
        $display("FAIL %s expectation at cycle %0d never checked: actual none expected %0b",
                 expQ[i].req, expQ[i].at, expQ[i].val);
      end
    end
    summary();
  end

endmodule